// File: doc/BRIEF.md
# Processor Reset Sequencer

This block generates the two active-low reset lines of an embedded 64-bit processor: a cold reset that reinitialises the core and a warm reset that only raises a reset exception. It runs on the processor's master clock. It takes a power-good indication, a cold-reset request and a soft-reset request. From these it produces three sequences: power-on, cold and soft (warm). Each sequence holds its reset lines low for a guaranteed number of master-clock cycles. Both lines are released on clock edges, so the processor's setup and hold windows are met.

The block also latches the clock-ratio mode pins when power is applied and drives the frozen copy from then on. Later changes on the mode pins cannot reach the processor. A busy output shows that a sequence is in progress. A one-cycle done pulse marks the moment the processor is released.

The hold lengths are parameters. The cold hold defaults to 64000 cycles and the warm hold to 16. The internal counter is sized from the larger of the two.

Top module: `cpu_reset_sequencer`

## Requirements
- R1: While the block's own reset `rstN` is low, both `cpuColdRstN` and `cpuWarmRstN` are 0, `busy` is 1 and `donePulse` is 0.
- R2: Power-up is the power-on state followed by `COLD_CYCLES` more cycles of cold hold. During power-up `cpuColdRstN` stays 0. The cold hold begins once the synchronised power-good is seen high.
- R3: After `cpuColdRstN` rises, `cpuWarmRstN` stays 0 for exactly `WARM_CYCLES` cycles and then rises.
- R4: `coldReq`=1 is sampled at a clock edge while in run, warm hold or soft hold. From the next cycle, `cpuColdRstN` is 0 for exactly `COLD_CYCLES` cycles, and then R3 applies.
- R5: `softReq`=1 is sampled in run. From the next cycle, `cpuWarmRstN` is 0 for exactly `WARM_CYCLES` cycles while `cpuColdRstN` stays 1.
- R6: `softReq` has no effect during power-on, cold hold or warm hold. No extra warm-reset pulse follows the sequence in progress.
- R7: `coldReq` during a soft hold aborts it and runs the full cold sequence of R4.
- R8: `pwrGood` passes through a two-flop synchronizer. While `pwrGood` is low after reset, both resets remain 0. If `pwrGood` drops, both resets are 0 by the second clock edge after the drop, and a full R2 sequence follows its return.
- R9: `modeOut` takes `modeIn` at the edge that leaves the power-on state. It holds that value through cold and soft sequences, whatever `modeIn` does, until the next power-up.
- R10: `donePulse` is 1 for exactly one cycle. That cycle is the one in which `cpuWarmRstN` rises at the end of any sequence. `busy` is 1 whenever the processor is not released.
- R11: If `coldReq` and `softReq` are sampled together in run, the cold sequence is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor master clock |
| rstN | input | 1 | Active-low reset of this block |
| pwrGood | input | 1 | Power-good indication, asynchronous |
| coldReq | input | 1 | Cold-reset request, synchronous |
| softReq | input | 1 | Soft (warm) reset request, synchronous |
| modeIn | input | MODE_W | Clock-ratio mode pins as presented by the board |
| cpuColdRstN | output | 1 | Active-low cold reset to the processor |
| cpuWarmRstN | output | 1 | Active-low warm reset to the processor |
| modeOut | output | MODE_W | Frozen clock-ratio mode to the processor |
| busy | output | 1 | A reset sequence is in progress |
| donePulse | output | 1 | One-cycle pulse when both resets are released |

## Verification
The hardest situations to reach are requests that land inside another sequence. Examples are a soft request during the warm hold, which follows the cold hold, and a cold request in the few cycles of a soft hold. The stimulus times each request by counting master-clock edges from the request that started the sequence, using short hold parameters so the windows can be placed exactly. Loss of power is forced from run and answered with a soft request while the block sits in the power-on state. The test then checks that the mode pins are recaptured on the return of power.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_POWER_ON  = 3'd0,
    ST_COLD_HOLD = 3'd1,
    ST_WARM_HOLD = 3'd2,
    ST_RUN       = 3'd3,
    ST_SOFT_HOLD = 3'd4
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic modeCap;
  } dpStrobe_t;

endpackage

// File: rtl/rstseq_dpath.sv
module rstseq_dpath
  import rstseq_pkg::*;
#(
  parameter int unsigned COLD_CYCLES = 64000,
  parameter int unsigned WARM_CYCLES = 16,
  parameter int unsigned MODE_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic [MODE_W-1:0] modeIn,
  input  dpStrobe_t         strobe,
  output logic              pgSync,
  output logic              coldDone,
  output logic              warmDone,
  output logic [MODE_W-1:0] modeOut
);

  localparam int unsigned MAX_HOLD = (COLD_CYCLES > WARM_CYCLES) ? COLD_CYCLES : WARM_CYCLES;
  localparam int unsigned CNT_W    = $clog2(MAX_HOLD + 1);

  logic             pgMeta;
  logic [CNT_W-1:0] holdCnt;

  // two-flop synchronizer for the asynchronous power-good input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgMeta <= 1'b0;
      pgSync <= 1'b0;
    end else begin
      pgMeta <= pwrGood;
      pgSync <= pgMeta;
    end
  end

  // cycles spent in the current state; saturates so it never wraps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.cntClr) begin
      holdCnt <= '0;
    end else if (holdCnt != '1) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // frozen clock-ratio mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeOut <= '0;
    end else if (strobe.modeCap) begin
      modeOut <= modeIn;
    end
  end

  assign coldDone = (holdCnt == CNT_W'(COLD_CYCLES - 1));
  assign warmDone = (holdCnt == CNT_W'(WARM_CYCLES - 1));

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pgSync,
  input  logic      coldReq,
  input  logic      softReq,
  input  logic      coldDone,
  input  logic      warmDone,
  output dpStrobe_t strobe,
  output logic      coldRstN,
  output logic      warmRstN,
  output logic      busy,
  output logic      donePulse
);

  seqState_t state, nextState;
  logic      doneQ;

  always_comb begin
    nextState = state;
    if (!pgSync) begin
      nextState = ST_POWER_ON;
    end else begin
      unique case (state)
        ST_POWER_ON:  nextState = ST_COLD_HOLD;
        ST_COLD_HOLD: if (coldDone) nextState = ST_WARM_HOLD;
        ST_WARM_HOLD: begin
          if (coldReq)       nextState = ST_COLD_HOLD;
          else if (warmDone) nextState = ST_RUN;
        end
        ST_RUN: begin
          if (coldReq)      nextState = ST_COLD_HOLD;
          else if (softReq) nextState = ST_SOFT_HOLD;
        end
        ST_SOFT_HOLD: begin
          if (coldReq)       nextState = ST_COLD_HOLD;
          else if (warmDone) nextState = ST_RUN;
        end
        default: nextState = ST_POWER_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_POWER_ON;
      doneQ <= 1'b0;
    end else begin
      state <= nextState;
      doneQ <= (nextState == ST_RUN) && (state != ST_RUN);
    end
  end

  assign strobe.cntClr  = (nextState != state);
  assign strobe.modeCap = (state == ST_POWER_ON) && pgSync;

  // loss of synchronised power-good forces both lines low at once
  assign coldRstN  = pgSync && (state == ST_WARM_HOLD || state == ST_RUN || state == ST_SOFT_HOLD);
  assign warmRstN  = pgSync && (state == ST_RUN);
  assign busy      = !pgSync || (state != ST_RUN);
  assign donePulse = doneQ && pgSync;

endmodule

// File: rtl/cpu_reset_sequencer.sv
module cpu_reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned COLD_CYCLES = 64000,
  parameter int unsigned WARM_CYCLES = 16,
  parameter int unsigned MODE_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              coldReq,
  input  logic              softReq,
  input  logic [MODE_W-1:0] modeIn,
  output logic              cpuColdRstN,
  output logic              cpuWarmRstN,
  output logic [MODE_W-1:0] modeOut,
  output logic              busy,
  output logic              donePulse
);

  dpStrobe_t strobe;
  logic      pgSync;
  logic      coldDone;
  logic      warmDone;

  rstseq_dpath #(
    .COLD_CYCLES(COLD_CYCLES),
    .WARM_CYCLES(WARM_CYCLES),
    .MODE_W     (MODE_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .pwrGood (pwrGood),
    .modeIn  (modeIn),
    .strobe  (strobe),
    .pgSync  (pgSync),
    .coldDone(coldDone),
    .warmDone(warmDone),
    .modeOut (modeOut)
  );

  rstseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pgSync   (pgSync),
    .coldReq  (coldReq),
    .softReq  (softReq),
    .coldDone (coldDone),
    .warmDone (warmDone),
    .strobe   (strobe),
    .coldRstN (cpuColdRstN),
    .warmRstN (cpuWarmRstN),
    .busy     (busy),
    .donePulse(donePulse)
  );

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker #(
  parameter int unsigned COLD_CYCLES = 64000,
  parameter int unsigned WARM_CYCLES = 16,
  parameter int unsigned MODE_W      = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              coldRstN,
  input logic              warmRstN,
  input logic [MODE_W-1:0] modeOut,
  input logic              busy,
  input logic              donePulse
);

  logic [31:0] coldRun;
  logic [31:0] warmRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coldRun <= '0;
      warmRun <= '0;
    end else begin
      if (!coldRstN) begin
        if (coldRun < COLD_CYCLES) coldRun <= coldRun + 1;
      end else begin
        coldRun <= '0;
      end
      if (coldRstN && !warmRstN) begin
        if (warmRun < WARM_CYCLES) warmRun <= warmRun + 1;
      end else begin
        warmRun <= '0;
      end
    end
  end

  // R1 / R2: cold reset never stands alone without warm reset
  a_r1_cold_implies_warm: assert property (@(posedge clk) disable iff (!rstN)
    !coldRstN |-> !warmRstN);

  // R2: cold reset low for at least the cold hold length before release
  a_r2_cold_min: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coldRstN) |-> (coldRun >= COLD_CYCLES));

  // R3 / R5: warm-only hold lasts at least the warm hold length
  a_r3_warm_min: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(warmRstN) && coldRstN) |-> (warmRun >= WARM_CYCLES));

  // R9: mode output only moves after a cycle with cold reset low
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    coldRstN |=> $stable(modeOut));

  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R10: done only while the processor is released and idle
  a_r10_done_released: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (coldRstN && warmRstN && !busy));

endmodule

bind cpu_reset_sequencer rstseq_checker #(
  .COLD_CYCLES(COLD_CYCLES),
  .WARM_CYCLES(WARM_CYCLES),
  .MODE_W     (MODE_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .coldRstN (cpuColdRstN),
  .warmRstN (cpuWarmRstN),
  .modeOut  (modeOut),
  .busy     (busy),
  .donePulse(donePulse)
);

// File: tb/cpu_reset_sequencer_tb.sv
`timescale 1ns/1ps
module cpu_reset_sequencer_tb;

  localparam int N  = 40;
  localparam int W  = 6;
  localparam int MW = 3;

  typedef struct {
    int    coldLen;
    bit    coldExact;
    int    warmLen;
    string tag;
  } seqItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pwrGood = 1'b0;
  logic          coldReq = 1'b0;
  logic          softReq = 1'b0;
  logic [MW-1:0] modeIn = 3'b101;
  logic          cpuColdRstN, cpuWarmRstN, busy, donePulse;
  logic [MW-1:0] modeOut;

  int       nChecks = 0;
  int       nFails  = 0;
  seqItem_t expQ[$];

  always #4 clk = ~clk;

  cpu_reset_sequencer #(.COLD_CYCLES(N), .WARM_CYCLES(W), .MODE_W(MW)) u_dut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .coldReq(coldReq), .softReq(softReq),
    .modeIn(modeIn), .cpuColdRstN(cpuColdRstN), .cpuWarmRstN(cpuWarmRstN),
    .modeOut(modeOut), .busy(busy), .donePulse(donePulse));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int c, input bit ex, input int w, input string tag);
    seqItem_t it;
    it.coldLen = c; it.coldExact = ex; it.warmLen = w; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic pulseCold();
    @(negedge clk) coldReq = 1'b1;
    @(negedge clk) coldReq = 1'b0;
  endtask

  task automatic pulseSoft();
    @(negedge clk) softReq = 1'b1;
    @(negedge clk) softReq = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  // monitor: measures each sequence at the ports and pops the scoreboard
  int coldCnt = 0, warmCnt = 0;
  bit prevCold = 1'b0, prevWarm = 1'b0, chkDoneLow = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (chkDoneLow) begin
        check(!donePulse, "R10", "done pulse lasts one cycle", int'(donePulse), 0);
        chkDoneLow = 1'b0;
      end
      if (!cpuColdRstN) begin
        if (prevCold) coldCnt = 0;
        coldCnt++;
        warmCnt = 0;
      end else if (!cpuWarmRstN) begin
        warmCnt++;
      end
      if (cpuWarmRstN && !prevWarm) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected release (no sequence expected)", 1, 0);
        end else begin
          seqItem_t it;
          it = expQ.pop_front();
          if (it.coldExact)
            check(coldCnt == it.coldLen, it.tag, "cold low cycles", coldCnt, it.coldLen);
          else
            check(coldCnt >= it.coldLen, it.tag, "cold low cycles (minimum)", coldCnt, it.coldLen);
          check(warmCnt == it.warmLen, "R3", "warm-only low cycles", warmCnt, it.warmLen);
          check(donePulse, "R10", "done with release", int'(donePulse), 1);
        end
        coldCnt = 0; warmCnt = 0; chkDoneLow = 1'b1;
      end
      prevCold = cpuColdRstN;
      prevWarm = cpuWarmRstN;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!cpuColdRstN, "R1", "cold during reset", int'(cpuColdRstN), 0);
    check(!cpuWarmRstN, "R1", "warm during reset", int'(cpuWarmRstN), 0);
    check(busy, "R1", "busy during reset", int'(busy), 1);
    check(!donePulse, "R1", "done during reset", int'(donePulse), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(!cpuColdRstN && !cpuWarmRstN, "R8", "resets held without power-good",
          int'({cpuColdRstN, cpuWarmRstN}), 0);

    // R2: power-up
    push(N, 1'b0, W, "R2");
    pwrGood = 1'b1;
    waitIdle();
    check(modeOut == 3'b101, "R9", "mode captured at power-up", int'(modeOut), 5);
    modeIn = 3'b010;
    repeat (4) @(negedge clk);
    check(modeOut == 3'b101, "R9", "mode frozen after input change", int'(modeOut), 5);

    // R5: soft reset
    push(0, 1'b1, W, "R5");
    pulseSoft();
    waitIdle();

    // R4: cold request from run
    push(N, 1'b1, W, "R4");
    pulseCold();
    check(busy, "R10", "busy during cold sequence", int'(busy), 1);
    waitIdle();
    check(modeOut == 3'b101, "R9", "mode kept through cold reset", int'(modeOut), 5);

    // R6: soft during cold hold
    push(N, 1'b1, W, "R6");
    pulseCold();
    repeat (10) @(negedge clk);
    pulseSoft();
    waitIdle();
    repeat (3 * W) @(negedge clk);
    check(cpuWarmRstN && !busy, "R6", "no warm pulse after soft in cold hold",
          int'({cpuWarmRstN, busy}), 2);

    // R6: soft during warm hold
    push(N, 1'b1, W, "R6");
    pulseCold();
    repeat (N + 2) @(negedge clk);
    pulseSoft();
    waitIdle();
    repeat (3 * W) @(negedge clk);
    check(cpuWarmRstN && !busy && expQ.size() == 0, "R6", "no warm pulse after soft in warm hold",
          expQ.size(), 0);

    // R7: cold during soft hold
    push(N, 1'b1, W, "R7");
    pulseSoft();
    repeat (2) @(negedge clk);
    pulseCold();
    waitIdle();

    // R11: simultaneous requests
    push(N, 1'b1, W, "R11");
    @(negedge clk) begin coldReq = 1'b1; softReq = 1'b1; end
    @(negedge clk) begin coldReq = 1'b0; softReq = 1'b0; end
    check(!cpuColdRstN, "R11", "cold taken over soft", int'(cpuColdRstN), 0);
    waitIdle();

    // R8: power loss in run, soft in power-on ignored, recapture of mode
    modeIn = 3'b110;
    @(negedge clk) pwrGood = 1'b0;
    repeat (2) @(negedge clk);
    check(!cpuColdRstN && !cpuWarmRstN && busy, "R8", "resets forced on power loss",
          int'({cpuColdRstN, cpuWarmRstN, busy}), 1);
    pulseSoft();
    repeat (4) @(negedge clk);
    check(!cpuWarmRstN, "R6", "soft ignored without power", int'(cpuWarmRstN), 0);
    push(N, 1'b0, W, "R8");
    pwrGood = 1'b1;
    waitIdle();
    check(modeOut == 3'b110, "R9", "mode recaptured on power return", int'(modeOut), 6);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R10", "all sequences completed", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule